// File: doc/BRIEF.md
# Circular Packet Buffer Writer

This block takes fixed-length transport packets arriving as 32-bit words and stores each accepted packet in a circular memory region as a 192-byte record. A record is a 4-byte header followed by the 188-byte packet, so every record is a multiple of 8 bytes. Records reach memory through a 64-bit write port, one aligned doubleword at a time. Software programs the region with a base address and an inclusive top address. It reads the block's write pointer and supplies its own read pointer. The block moves the write pointer forward by one record each time a record is complete. Software moves the read pointer as it consumes records.

The block never lets the write pointer catch up with the read pointer. A packet that does not fit is dropped whole. The drop is counted and flagged in the header of the next stored record. Each header also carries a 16-bit sequence number of stored records.

A start pulse rewinds the channel. An enable input gates new packets. Software stops a channel through an idle request word that carries one bit per channel plus a request flag. The block answers with an interrupt once no record is in flight, and the interrupt falls when software writes the word back to zero.

Top module: `pkt_ring_writer`

## Requirements
- R1: A record occupies 24 doublewords written to consecutive 8-byte-aligned addresses from the record start. Doubleword 0 holds the header in bits 31:0 and packet word 0 in bits 63:32. Doubleword k (k ≥ 1) holds packet word 2k-1 in bits 31:0 and packet word 2k in bits 63:32. In the header, bits 15:0 are the sequence number, bit 31 is the drop flag, and the other bits are zero.
- R2: The write pointer output changes only after the last doubleword of a record is issued. It then points to the start of the next record.
- R3: When the current write pointer plus 192 exceeds the top address, the write pointer returns to the base address.
- R4: A packet start is accepted only when the free space is greater than 192 bytes. Free space is rp−wp when rp>wp, and otherwise (top−base+1)−(wp−rp). A packet that does not fit causes no write. It increments the drop counter and sets the drop flag in the next stored header; storing that header clears the flag.
- R5: The sequence number starts at 0 after a start pulse and increases by one for each stored record.
- R6: While enable is low, packet starts are ignored: no write, no drop count. A record already in flight still completes.
- R7: A start pulse sets the write pointer to the base address, clears the sequence number, the drop counter and the drop flag, and abandons any record in flight.
- R8: When the request flag (bit NCHAN) and this channel's bit (bit CHAN_IDX) are both set, no new packet is started. The interrupt rises only after the last doubleword of any record in flight has been issued. It falls after the request word returns to zero.
- R9: A request word without the flag, or without this channel's bit, raises no interrupt and does not block packets.
- R10: After reset the write pointer, drop counter, interrupt and write strobe are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | ADDR_W | First byte address of the region |
| top_i | input | ADDR_W | Last valid byte address of the region |
| rd_ptr_i | input | ADDR_W | Software read pointer |
| en_i | input | 1 | Channel enable |
| start_i | input | 1 | Rewind pulse |
| idle_req_i | input | NCHAN+1 | Idle request: per-channel bits plus flag in the top bit |
| pkt_valid_i | input | 1 | Packet word valid |
| pkt_sop_i | input | 1 | First word of a packet |
| pkt_data_i | input | 32 | Packet word |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory byte address, 8-byte aligned |
| mem_wdata_o | output | 64 | Memory write data |
| wr_ptr_o | output | ADDR_W | Write pointer |
| drop_cnt_o | output | CNT_W | Dropped packet count |
| idle_irq_o | output | 1 | Idle acknowledge interrupt |

## Verification
The hardest situations to reach are the record that lands exactly at the top of the region, and the state where a drop flag is waiting for the next header. Both only occur after the ring has been filled to its limit of one record short of the read pointer. The bench uses the smallest legal region of eight records. It fills that region with the read pointer held at the base until a packet is refused. It then moves the read pointer ahead so that the next record lands in the last slot and forces the wrap. An idle request raised in the middle of a packet covers the case where the acknowledge has to wait for the last doubleword.

// File: rtl/pkt_ring_pkg.sv
package pkt_ring_pkg;

    typedef enum logic {
        WR_IDLE = 1'b0,
        WR_BUSY = 1'b1
    } wr_state_e;

    function automatic logic [31:0] make_header(input logic [15:0] seq, input logic drop_flag);
        return {drop_flag, 15'd0, seq};
    endfunction

endpackage

// File: rtl/ring_space.sv
module ring_space #(
    parameter int ADDR_W    = 32,
    parameter int REC_BYTES = 192
) (
    input  logic [ADDR_W-1:0] wp_i,
    input  logic [ADDR_W-1:0] rp_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] top_i,
    output logic              room_o,
    output logic [ADDR_W-1:0] next_wp_o
);
    localparam logic [ADDR_W:0] REC_EXT = (ADDR_W+1)'(REC_BYTES);

    logic [ADDR_W:0] size_ext;
    logic [ADDR_W:0] free_ext;
    logic [ADDR_W:0] step_ext;

    always_comb begin
        size_ext = {1'b0, top_i} - {1'b0, base_i} + (ADDR_W+1)'(1);
        if (rp_i > wp_i) begin
            free_ext = {1'b0, rp_i} - {1'b0, wp_i};
        end else begin
            free_ext = size_ext - ({1'b0, wp_i} - {1'b0, rp_i});
        end
        room_o   = free_ext > REC_EXT;
        step_ext = {1'b0, wp_i} + REC_EXT;
        if (step_ext > {1'b0, top_i}) begin
            next_wp_o = base_i;
        end else begin
            next_wp_o = step_ext[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/pkt_ring_writer.sv
module pkt_ring_writer
    import pkt_ring_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PKT_WORDS = 47,
    parameter int SEQ_W     = 16,
    parameter int CNT_W     = 16,
    parameter int NCHAN     = 4,
    parameter int CHAN_IDX  = 0
) (
    input  logic              clk,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] top_i,
    input  logic [ADDR_W-1:0] rd_ptr_i,
    input  logic              en_i,
    input  logic              start_i,
    input  logic [NCHAN:0]    idle_req_i,
    input  logic              pkt_valid_i,
    input  logic              pkt_sop_i,
    input  logic [31:0]       pkt_data_i,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [63:0]       mem_wdata_o,
    output logic [ADDR_W-1:0] wr_ptr_o,
    output logic [CNT_W-1:0]  drop_cnt_o,
    output logic              idle_irq_o
);
    localparam int REC_BYTES = 4 + 4 * PKT_WORDS;
    localparam int IDX_W     = $clog2(PKT_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_WORDS - 1);

    typedef struct packed {
        wr_state_e         st;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] rec;
        logic [ADDR_W-1:0] wp;
        logic [SEQ_W-1:0]  seq;
        logic              drop_flag;
        logic [CNT_W-1:0]  drops;
        logic [31:0]       hold;
        logic              we;
        logic [ADDR_W-1:0] waddr;
        logic [63:0]       wdata;
        logic              irq;
    } wr_regs_t;

    wr_regs_t r_d, r_q;

    logic              room;
    logic [ADDR_W-1:0] next_wp;
    logic              req_hit;

    ring_space #(
        .ADDR_W    (ADDR_W),
        .REC_BYTES (REC_BYTES)
    ) u_space (
        .wp_i      (r_q.wp),
        .rp_i      (rd_ptr_i),
        .base_i    (base_i),
        .top_i     (top_i),
        .room_o    (room),
        .next_wp_o (next_wp)
    );

    assign req_hit = idle_req_i[NCHAN] && idle_req_i[CHAN_IDX];

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        if (start_i) begin
            r_d.st        = WR_IDLE;
            r_d.idx       = '0;
            r_d.wp        = base_i;
            r_d.seq       = '0;
            r_d.drop_flag = 1'b0;
            r_d.drops     = '0;
        end else begin
            unique case (r_q.st)
                WR_IDLE: begin
                    if (pkt_valid_i && pkt_sop_i && en_i && !req_hit) begin
                        if (room) begin
                            r_d.st        = WR_BUSY;
                            r_d.rec       = r_q.wp;
                            r_d.idx       = IDX_W'(1);
                            r_d.we        = 1'b1;
                            r_d.waddr     = r_q.wp;
                            r_d.wdata     = {pkt_data_i,
                                             make_header(16'(r_q.seq), r_q.drop_flag)};
                            r_d.drop_flag = 1'b0;
                        end else begin
                            r_d.drops     = r_q.drops + CNT_W'(1);
                            r_d.drop_flag = 1'b1;
                        end
                    end
                end
                WR_BUSY: begin
                    if (pkt_valid_i) begin
                        if (r_q.idx[0]) begin
                            r_d.hold = pkt_data_i;
                        end else begin
                            r_d.we    = 1'b1;
                            r_d.waddr = r_q.rec + (ADDR_W'(r_q.idx >> 1) << 3);
                            r_d.wdata = {pkt_data_i, r_q.hold};
                        end
                        if (r_q.idx == LAST_IDX) begin
                            r_d.st  = WR_IDLE;
                            r_d.wp  = next_wp;
                            r_d.seq = r_q.seq + SEQ_W'(1);
                        end else begin
                            r_d.idx = r_q.idx + IDX_W'(1);
                        end
                    end
                end
                default: r_d.st = WR_IDLE;
            endcase
        end
        r_d.irq = req_hit && (r_q.st == WR_IDLE);
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_we_o    = r_q.we;
    assign mem_addr_o  = r_q.waddr;
    assign mem_wdata_o = r_q.wdata;
    assign wr_ptr_o    = r_q.wp;
    assign drop_cnt_o  = r_q.drops;
    assign idle_irq_o  = r_q.irq;

    // R1: every memory write is doubleword aligned
    assert_aligned_write_R1: assert property (@(posedge clk) disable iff (!rst_ni)
        mem_we_o |-> (mem_addr_o[2:0] == 3'b000));

    // R3: the pointer only steps by one record or returns to the base
    assert_wp_step_R3: assert property (@(posedge clk) disable iff (!rst_ni)
        (!$stable(wr_ptr_o) && !$past(start_i)) |->
        ((wr_ptr_o == $past(wr_ptr_o) + ADDR_W'(REC_BYTES)) || (wr_ptr_o == base_i)));

    // R4: drop counter grows by at most one per cycle
    assert_drop_step_R4: assert property (@(posedge clk) disable iff (!rst_ni)
        !$past(start_i) |->
        ((drop_cnt_o == $past(drop_cnt_o)) || (drop_cnt_o == $past(drop_cnt_o) + CNT_W'(1))));

    // R6: disabled and not in flight means no write on the next cycle
    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_ni)
        (!en_i && r_q.st == WR_IDLE) |=> !mem_we_o);

    // R8: acknowledge never coincides with a write
    assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_ni)
        idle_irq_o |-> !mem_we_o);

endmodule

// File: tb/pkt_ring_writer_tb.sv
module pkt_ring_writer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 32;
    localparam int NW   = 47;
    localparam int REC  = 192;
    localparam int NREC = 8;
    localparam logic [AW-1:0] BASE = 32'h0000_1000;
    localparam logic [AW-1:0] TOP  = BASE + AW'(NREC * REC) - 1;
    localparam logic [4:0] REQ_SELF  = 5'b10001;
    localparam logic [4:0] REQ_OTHER = 5'b10100;
    localparam logic [4:0] REQ_NOFLG = 5'b00001;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic [AW-1:0] rd_ptr = BASE;
    logic en = 1'b1, start = 1'b0, valid = 1'b0, sop = 1'b0;
    logic [4:0] req = '0;
    logic [31:0] data = '0;
    logic we;
    logic [AW-1:0] waddr, wp;
    logic [63:0] wdata;
    logic [15:0] drops;
    logic irq;

    int n_chk = 0, n_err = 0, wcount = 0;
    logic irq_seen;
    logic [63:0] mem [0:NREC*REC/8-1];

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_ring_writer u_dut (
        .clk(clk), .rst_ni(rst_ni), .base_i(BASE), .top_i(TOP), .rd_ptr_i(rd_ptr),
        .en_i(en), .start_i(start), .idle_req_i(req), .pkt_valid_i(valid),
        .pkt_sop_i(sop), .pkt_data_i(data), .mem_we_o(we), .mem_addr_o(waddr),
        .mem_wdata_o(wdata), .wr_ptr_o(wp), .drop_cnt_o(drops), .idle_irq_o(irq)
    );

    always @(negedge clk) begin
        if (we) begin
            wcount++;
            if (waddr >= BASE && waddr <= TOP) mem[(waddr - BASE) >> 3] = wdata;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        idle(1);
    endtask

    // act: 1 = drop enable, 2 = raise own idle request, 3 = start pulse
    task automatic send_pkt(input logic [15:0] tag, input int act_at, input int act);
        irq_seen = 1'b0;
        for (int i = 0; i < NW; i++) begin
            @(negedge clk);
            if (irq) irq_seen = 1'b1;
            start = 1'b0;
            if (i == act_at) begin
                case (act)
                    1: en = 1'b0;
                    2: req = REQ_SELF;
                    3: start = 1'b1;
                    default: ;
                endcase
            end
            valid = 1'b1;
            sop   = (i == 0);
            data  = {tag, 16'(i)};
        end
        @(negedge clk);
        valid = 1'b0; sop = 1'b0; start = 1'b0;
        idle(3);
    endtask

    function automatic logic [31:0] pw(input logic [15:0] tag, input int i);
        return {tag, 16'(i)};
    endfunction

    task automatic check_record(input int slot, input logic [15:0] tag, input logic [15:0] seq,
                                input logic flag, input string rq);
        int bad = 0;
        logic [63:0] exp0;
        exp0 = {pw(tag, 0), flag, 15'd0, seq};
        chk(mem[slot*24] == exp0, {rq, " header doubleword"}, mem[slot*24], exp0);
        for (int k = 1; k < 24; k++) begin
            if (mem[slot*24+k] != {pw(tag, 2*k), pw(tag, 2*k-1)}) bad++;
        end
        chk(bad == 0, {rq, " payload doublewords"}, 64'(bad), 64'd0);
    endtask

    task automatic t_reset();
        chk(wp == '0, "R10 wp after reset", 64'(wp), 64'd0);
        chk(drops == '0, "R10 drops after reset", 64'(drops), 64'd0);
        chk(!irq && !we, "R10 irq/we after reset", {62'd0, irq, we}, 64'd0);
    endtask

    task automatic t_single();
        int w0;
        rd_ptr = BASE; do_start();
        chk(wp == BASE, "R7 wp at base after start", 64'(wp), 64'(BASE));
        w0 = wcount;
        send_pkt(16'hA100, -1, 0);
        chk(wcount - w0 == 24, "R1 writes per record", 64'(wcount - w0), 64'd24);
        check_record(0, 16'hA100, 16'd0, 1'b0, "R1 R5");
        chk(wp == BASE + REC, "R2 wp after record", 64'(wp), 64'(BASE + REC));
    endtask

    task automatic t_fill_wrap();
        int w0;
        rd_ptr = BASE; do_start();
        for (int i = 0; i < 7; i++) send_pkt(16'hB000 + 16'(i), -1, 0);
        chk(wp == BASE + 7*REC, "R2 wp after seven records", 64'(wp), 64'(BASE + 7*REC));
        check_record(6, 16'hB006, 16'd6, 1'b0, "R5 seventh record");
        w0 = wcount;
        send_pkt(16'hB0FF, -1, 0);
        chk(wcount == w0, "R4 full packet not written", 64'(wcount - w0), 64'd0);
        chk(drops == 16'd1, "R4 drop counted", 64'(drops), 64'd1);
        chk(wp == BASE + 7*REC, "R4 wp held on drop", 64'(wp), 64'(BASE + 7*REC));
        rd_ptr = BASE + 2*REC;
        send_pkt(16'hB007, -1, 0);
        check_record(7, 16'hB007, 16'd7, 1'b1, "R4 flag in next header");
        chk(wp == BASE, "R3 wrap to base", 64'(wp), 64'(BASE));
        send_pkt(16'hB008, -1, 0);
        check_record(0, 16'hB008, 16'd8, 1'b0, "R4 flag cleared");
        chk(wp == BASE + REC, "R3 after wrap", 64'(wp), 64'(BASE + REC));
        w0 = wcount;
        send_pkt(16'hB009, -1, 0);
        chk(wcount == w0 && drops == 16'd2, "R4 exact-fit refused", 64'(drops), 64'd2);
    endtask

    task automatic t_enable();
        int w0;
        logic [AW-1:0] wp0;
        rd_ptr = BASE; do_start();
        en = 1'b0; w0 = wcount; wp0 = wp;
        send_pkt(16'hC000, -1, 0);
        chk(wcount == w0, "R6 disabled no writes", 64'(wcount - w0), 64'd0);
        chk(wp == wp0 && drops == 0, "R6 disabled wp/drops unchanged", 64'(wp), 64'(wp0));
        en = 1'b1; w0 = wcount;
        send_pkt(16'hC001, 5, 1);
        chk(wcount - w0 == 24, "R6 in-flight record completes", 64'(wcount - w0), 64'd24);
        chk(wp == BASE + REC, "R6 wp advanced", 64'(wp), 64'(BASE + REC));
        en = 1'b1;
    endtask

    task automatic t_idle();
        int w0;
        logic [AW-1:0] wp0;
        rd_ptr = BASE; do_start();
        w0 = wcount;
        send_pkt(16'hD000, 10, 2);
        chk(!irq_seen, "R8 no ack while record in flight", 64'(irq_seen), 64'd0);
        chk(irq, "R8 ack after record done", 64'(irq), 64'd1);
        chk(wcount - w0 == 24, "R8 record fully written", 64'(wcount - w0), 64'd24);
        w0 = wcount; wp0 = wp;
        send_pkt(16'hD001, -1, 0);
        chk(wcount == w0 && wp == wp0, "R8 no new packet while requested", 64'(wcount - w0), 64'd0);
        req = '0; idle(2);
        chk(!irq, "R8 ack falls after clear", 64'(irq), 64'd0);
        req = REQ_OTHER; w0 = wcount;
        send_pkt(16'hD002, -1, 0);
        chk(!irq_seen && !irq, "R9 other channel bit no ack", 64'(irq), 64'd0);
        chk(wcount - w0 == 24, "R9 other channel bit does not block", 64'(wcount - w0), 64'd24);
        req = REQ_NOFLG; idle(3);
        chk(!irq, "R9 no flag no ack", 64'(irq), 64'd0);
        req = '0;
    endtask

    task automatic t_restart();
        int w0;
        rd_ptr = BASE; do_start();
        send_pkt(16'hE000, -1, 0);
        w0 = wcount;
        send_pkt(16'hE001, 20, 3);
        chk(wcount - w0 == 10, "R7 record abandoned", 64'(wcount - w0), 64'd10);
        chk(wp == BASE, "R7 wp rewound", 64'(wp), 64'(BASE));
        send_pkt(16'hE002, -1, 0);
        check_record(0, 16'hE002, 16'd0, 1'b0, "R7 sequence restarted");
    endtask

    logic done = 1'b0;

    initial begin
        idle(3);
        t_reset();
        @(negedge clk); rst_ni = 1'b1;
        idle(2);
        t_single();
        t_fill_wrap();
        t_enable();
        t_idle();
        t_restart();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule